// File: doc/BRIEF.md
# Transmit Queue Channel Steering Scheduler

The scheduler watches sixteen transmit queues, each with a pending-frame request line, and decides which queue sends its next frame descriptor. Each queue is assigned by configuration to one of eight transmit FIFO channels, and several queues may share a channel. Channels 0 to 3 carry background, best-effort, video and voice/management traffic, in rising priority. Channel 7 carries commands and is served first. Channels 4 to 6 are unused.

Each queue has a small context. A status word holds the channel number, an active flag and a scheduler enable. A context word holds a credit count and a super-credit byte. A queue is eligible when it is active, enabled, has a frame pending and has non-zero credit. The block picks the highest-priority channel that has an eligible queue. Within that channel it picks a queue round-robin, starting after the queue it last granted there. It then offers a grant that carries the queue index and the channel number. The grant stays on the outputs until the consumer accepts it. Acceptance uses one credit.

The control is a two-state machine. In ST_IDLE the block evaluates eligibility. If any queue is eligible it captures the winner and takes transition T_PICK to ST_OFFER. If none is eligible it takes T_WAIT and stays in ST_IDLE. In ST_OFFER the grant is valid. It stays there (T_HOLD) while ready is low. On acceptance it takes T_ACCEPT back to ST_IDLE, which decrements the credit and updates the channel's round-robin pointer. An accepted grant therefore occupies two cycles.

Top module: `txs_sched`

## Requirements
- R1: After reset, `gnt_valid` is 0, and every status and context word of every queue reads as zero.
- R2: A status write (`wr_sel`=0) stores the channel from bits 2:0, the active flag from bit 3 and the scheduler enable from bit 19. A status read returns those bits in the same positions and all other bits as 0.
- R3: A context write (`wr_sel`=1) stores the credit from bits 23:8 and the super-credit from bits 31:24. A context read returns those fields in the same positions and bits 7:0 as 0.
- R4: A queue is offered only when its active flag, its scheduler enable and its pending input are all 1 and its credit is non-zero. If any of these is missing, no grant is offered for it.
- R5: Each accepted grant (`gnt_valid` and `gnt_ready` both high at a clock edge) lowers the granted queue's credit by exactly one.
- R6: Among channels that have an eligible queue, channel 7 wins first, then the highest-numbered of channels 3 down to 0.
- R7: A queue assigned to channel 4, 5 or 6 is never granted, and its credit is left unchanged.
- R8: Within a channel, the granted queue is the first eligible queue in ascending index order, wrapping modulo 16, after the queue last accepted on that channel. Before any acceptance on a channel, the search starts at queue 0.
- R9: While `gnt_valid` is 1 and `gnt_ready` is 0, the grant, its queue and its channel stay unchanged, and no credit is consumed.
- R10: The super-credit field has no effect on eligibility. A queue with zero credit and a non-zero super-credit is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_pend | input | 16 | Per-queue frame-pending request |
| wr_en | input | 1 | Context write strobe |
| wr_sel | input | 1 | Write target: 0 status word, 1 context word |
| wr_q | input | 4 | Queue index for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 status word, 1 context word |
| rd_q | input | 4 | Queue index for the read |
| rd_data | output | 32 | Combinational read data |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Grant accepted by the downstream consumer |
| gnt_q | output | 4 | Granted queue index |
| gnt_ch | output | 3 | Channel of the granted queue |

## Verification
The hardest situation to reach is the round-robin pointer of one channel wrapping past queue 15 while other channels are also competing. That pointer is only visible through the order of later grants. The stimulus maps two queues onto each channel, gives every queue a few credits, and holds several distinct pending patterns steady. Each pattern runs until all credits are used up. Over a long sequence, the bench model's predicted winner for every accepted grant must match the design's, including the channel priority.

// File: rtl/txs_pkg.sv
package txs_pkg;
    localparam int STAT_CH_LSB  = 0;
    localparam int STAT_ACT_BIT = 3;
    localparam int STAT_EN_BIT  = 19;
    localparam int CTX_CR_LSB   = 8;
    localparam int CTX_SC_LSB   = 24;
    localparam int WORD_W       = 32;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } txs_state_e;
endpackage

// File: rtl/txs_ctx.sv
module txs_ctx
    import txs_pkg::*;
#(
    parameter int NQ   = 16,
    parameter int CH_W = 3,
    parameter int CR_W = 16,
    parameter int SC_W = 8,
    localparam int QW  = $clog2(NQ)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_sel,
    input  logic [QW-1:0]              wr_q,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       rd_sel,
    input  logic [QW-1:0]              rd_q,
    output logic [WORD_W-1:0]          rd_data,
    input  logic                       dec_en,
    input  logic [QW-1:0]              dec_q,
    output logic [NQ-1:0][CH_W-1:0]    ch_map,
    output logic [NQ-1:0]              act_vec,
    output logic [NQ-1:0]              en_vec,
    output logic [NQ-1:0]              cred_nz
);
    logic [NQ-1:0][CH_W-1:0] ch_r;
    logic [NQ-1:0]           act_r;
    logic [NQ-1:0]           en_r;
    logic [NQ-1:0][CR_W-1:0] cred_r;
    logic [NQ-1:0][SC_W-1:0] sc_r;

    // Register writes take precedence over a same-cycle credit decrement.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_r   <= '0;
            act_r  <= '0;
            en_r   <= '0;
            cred_r <= '0;
            sc_r   <= '0;
        end else begin
            for (int i = 0; i < NQ; i++) begin
                if (wr_en && wr_q == QW'(i)) begin
                    if (!wr_sel) begin
                        ch_r[i]  <= wr_data[STAT_CH_LSB +: CH_W];
                        act_r[i] <= wr_data[STAT_ACT_BIT];
                        en_r[i]  <= wr_data[STAT_EN_BIT];
                    end else begin
                        cred_r[i] <= wr_data[CTX_CR_LSB +: CR_W];
                        sc_r[i]   <= wr_data[CTX_SC_LSB +: SC_W];
                    end
                end else if (dec_en && dec_q == QW'(i) && cred_r[i] != '0) begin
                    cred_r[i] <= cred_r[i] - CR_W'(1);
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_sel) begin
            rd_data[STAT_CH_LSB +: CH_W] = ch_r[rd_q];
            rd_data[STAT_ACT_BIT]        = act_r[rd_q];
            rd_data[STAT_EN_BIT]         = en_r[rd_q];
        end else begin
            rd_data[CTX_CR_LSB +: CR_W]  = cred_r[rd_q];
            rd_data[CTX_SC_LSB +: SC_W]  = sc_r[rd_q];
        end
    end

    assign ch_map  = ch_r;
    assign act_vec = act_r;
    assign en_vec  = en_r;

    for (genvar g = 0; g < NQ; g++) begin : g_nz
        assign cred_nz[g] = (cred_r[g] != '0);
    end

    // R5: an uncontested decrement lowers the credit by exactly one
    assert_credit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !(wr_en && wr_q == dec_q) && cred_r[dec_q] != '0)
        |=> cred_r[$past(dec_q)] == $past(cred_r[dec_q]) - CR_W'(1));
endmodule

// File: rtl/txs_rr.sv
module txs_rr #(
    parameter int N   = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] win,
    output logic          hit
);
    // First requester after 'last', wrapping modulo N.
    always_comb begin
        win = last;
        hit = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!hit && req[idx]) begin
                hit = 1'b1;
                win = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/txs_pick.sv
module txs_pick #(
    parameter int NQ            = 16,
    parameter int NCH           = 8,
    parameter int CH_W          = 3,
    parameter logic [NCH-1:0] CH_ALLOW = 8'b1000_1111,
    localparam int QW           = $clog2(NQ)
) (
    input  logic [NQ-1:0]            elig,
    input  logic [NQ-1:0][CH_W-1:0]  ch_map,
    input  logic [NCH-1:0][QW-1:0]   last_ptr,
    output logic                     sel_valid,
    output logic [QW-1:0]            sel_q,
    output logic [CH_W-1:0]          sel_ch
);
    logic [NCH-1:0][NQ-1:0] chreq;
    logic [NCH-1:0][QW-1:0] win_c;
    logic [NCH-1:0]         hit_c;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int q = 0; q < NQ; q++) begin
                chreq[c][q] = elig[q] && (ch_map[q] == CH_W'(c)) && CH_ALLOW[c];
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        txs_rr #(.N(NQ)) u_rr (
            .req  (chreq[c]),
            .last (last_ptr[c]),
            .win  (win_c[c]),
            .hit  (hit_c[c])
        );
    end

    // Highest-numbered allowed channel with a requester wins.
    always_comb begin
        sel_q  = '0;
        sel_ch = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit_c[c]) begin
                sel_q  = win_c[c];
                sel_ch = CH_W'(c);
            end
        end
        sel_valid = |hit_c;
    end
endmodule

// File: rtl/txs_sched.sv
module txs_sched
    import txs_pkg::*;
#(
    parameter int NQ   = 16,
    parameter int NCH  = 8,
    parameter int CR_W = 16,
    parameter int SC_W = 8,
    parameter logic [NCH-1:0] CH_ALLOW = 8'b1000_1111,
    localparam int QW   = $clog2(NQ),
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NQ-1:0]     q_pend,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [QW-1:0]     wr_q,
    input  logic [31:0]       wr_data,
    input  logic              rd_sel,
    input  logic [QW-1:0]     rd_q,
    output logic [31:0]       rd_data,
    output logic              gnt_valid,
    input  logic              gnt_ready,
    output logic [QW-1:0]     gnt_q,
    output logic [CH_W-1:0]   gnt_ch
);
    txs_state_e state_r, state_n;

    logic [NQ-1:0][CH_W-1:0] ch_map;
    logic [NQ-1:0]           act_vec, en_vec, cred_nz, elig;
    logic [NCH-1:0][QW-1:0]  last_r;
    logic                    pick_valid;
    logic [QW-1:0]           pick_q, gnt_q_r;
    logic [CH_W-1:0]         pick_ch, gnt_ch_r;
    logic                    accept;

    txs_ctx #(.NQ(NQ), .CH_W(CH_W), .CR_W(CR_W), .SC_W(SC_W)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_q    (wr_q),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_q    (rd_q),
        .rd_data (rd_data),
        .dec_en  (accept),
        .dec_q   (gnt_q_r),
        .ch_map  (ch_map),
        .act_vec (act_vec),
        .en_vec  (en_vec),
        .cred_nz (cred_nz)
    );

    assign elig = act_vec & en_vec & q_pend & cred_nz;

    txs_pick #(.NQ(NQ), .NCH(NCH), .CH_W(CH_W), .CH_ALLOW(CH_ALLOW)) u_pick (
        .elig      (elig),
        .ch_map    (ch_map),
        .last_ptr  (last_r),
        .sel_valid (pick_valid),
        .sel_q     (pick_q),
        .sel_ch    (pick_ch)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= ST_IDLE;
        else        state_r <= state_n;
    end

    // Next state: T_PICK, T_WAIT, T_HOLD, T_ACCEPT
    always_comb begin
        state_n = state_r;
        unique case (state_r)
            ST_IDLE:  if (pick_valid) state_n = ST_OFFER;
            ST_OFFER: if (gnt_ready)  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        gnt_valid = 1'b0;
        unique case (state_r)
            ST_IDLE:  gnt_valid = 1'b0;
            ST_OFFER: gnt_valid = 1'b1;
            default:  gnt_valid = 1'b0;
        endcase
    end

    assign accept = (state_r == ST_OFFER) && gnt_ready;
    assign gnt_q  = gnt_q_r;
    assign gnt_ch = gnt_ch_r;

    // Grant capture and per-channel round-robin pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_q_r  <= '0;
            gnt_ch_r <= '0;
            for (int c = 0; c < NCH; c++) last_r[c] <= QW'(NQ - 1);
        end else begin
            if (state_r == ST_IDLE && pick_valid) begin
                gnt_q_r  <= pick_q;
                gnt_ch_r <= pick_ch;
            end
            if (accept) last_r[gnt_ch_r] <= gnt_q_r;
        end
    end

    // Checker support: eligibility seen in the deciding cycle
    logic [NQ-1:0] elig_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elig_d <= '0;
        else        elig_d <= elig;
    end

    assert_hold_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_q) && $stable(gnt_ch)));

    assert_legal_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> CH_ALLOW[gnt_ch]);

    assert_eligible_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> elig_d[gnt_q]);

    assert_channel_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> $past(ch_map[pick_q]) == gnt_ch);
endmodule

// File: tb/sim_txs_sched.sv
`timescale 1ns/1ps
module sim_txs_sched;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] q_pend = '0;
    logic        wr_en = 0, wr_sel = 0, rd_sel = 0, gnt_ready = 0;
    logic [3:0]  wr_q = '0, rd_q = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        gnt_valid;
    logic [3:0]  gnt_q;
    logic [2:0]  gnt_ch;

    int errs = 0, checks = 0;
    int mch[16], mcred[16], mlast[8];
    bit mact[16], men[16];

    always #2.5 clk = ~clk;

    txs_sched u0 (
        .clk(clk), .rst_n(rst_n), .q_pend(q_pend),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_q(wr_q), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_q(rd_q), .rd_data(rd_data),
        .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_q(gnt_q), .gnt_ch(gnt_ch)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(bit sel, int q, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_q = 4'(q); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(bit sel, int q, output logic [31:0] d);
        rd_sel = sel; rd_q = 4'(q);
        #0.1;
        d = rd_data;
    endtask

    function automatic int predict(logic [15:0] pend, output int pc);
        int order[5] = '{7, 3, 2, 1, 0};
        pc = -1;
        foreach (order[i]) begin
            for (int k = 1; k <= 16; k++) begin
                int q;
                q = (mlast[order[i]] + k) % 16;
                if (mch[q] == order[i] && mact[q] && men[q] && pend[q] && mcred[q] > 0) begin
                    pc = order[i];
                    return q;
                end
            end
        end
        return -1;
    endfunction

    initial begin
        #750000;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] pats[4] = '{16'hFFFF, 16'h5555, 16'hF0F0, 16'h8181};
        for (int c = 0; c < 8; c++) mlast[c] = 15;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 valid", 32'(gnt_valid), 0);
        for (int q = 0; q < 16; q++) begin
            rd(0, q, d); chk("R1 status", d, 0);
            rd(1, q, d); chk("R1 context", d, 0);
        end

        // R2, R3: field placement
        wr(0, 5, 32'hFFFF_FFFF);
        rd(0, 5, d); chk("R2 status fields", d, 32'h0008_000F);
        wr(1, 5, 32'hFFFF_FFFF);
        rd(1, 5, d); chk("R3 context fields", d, 32'hFFFF_FF00);

        // R6 R8 R7 R5: sweep of pending patterns
        gnt_ready = 1;
        foreach (pats[p]) begin
            int ngr, nexp;
            ngr = 0; nexp = 0;
            for (int q = 0; q < 16; q++) begin
                wr(0, q, 32'(q % 8) | (32'd1 << 3) | (32'd1 << 19));
                wr(1, q, 32'd3 << 8);
                mch[q] = q % 8; mact[q] = 1; men[q] = 1; mcred[q] = 3;
                if (pats[p][q] && (q % 8 < 4 || q % 8 == 7)) nexp += 3;
            end
            q_pend = pats[p];
            for (int cyc = 0; cyc < 120; cyc++) begin
                @(negedge clk);
                if (gnt_valid) begin
                    int pq, pc;
                    pq = predict(pats[p], pc);
                    chk("R6 R8 grant queue", 32'(gnt_q), 32'(pq));
                    chk("R6 R7 grant channel", 32'(gnt_ch), 32'(pc));
                    if (pq >= 0) begin
                        mcred[pq]--;
                        mlast[pc] = pq;
                    end
                    ngr++;
                end
            end
            q_pend = '0;
            repeat (3) @(negedge clk);
            chk("R5 grant total", 32'(ngr), 32'(nexp));
            for (int q = 0; q < 16; q++) begin
                bit allowed;
                allowed = (q % 8 < 4) || (q % 8 == 7);
                rd(1, q, d);
                chk(allowed ? "R5 credit used" : "R7 credit kept", d,
                    (allowed && pats[p][q]) ? 32'd0 : (32'd3 << 8));
            end
        end

        // R4: exhaustive gating sweep on queue 2 (channel 1), others off
        for (int q = 0; q < 16; q++) wr(0, q, 0);
        for (int m = 0; m < 16; m++) begin
            int ngr;
            ngr = 0;
            wr(0, 2, 32'd1 | (32'(m & 1) << 3) | (32'((m >> 1) & 1) << 19));
            wr(1, 2, 32'((m >> 3) & 1) << 8);
            q_pend = 16'(((m >> 2) & 1) << 2);
            for (int cyc = 0; cyc < 6; cyc++) begin
                @(negedge clk);
                if (gnt_valid) ngr++;
            end
            q_pend = '0;
            repeat (2) @(negedge clk);
            chk("R4 gated grant", 32'(ngr), (m == 15) ? 1 : 0);
            rd(1, 2, d);
            chk("R4 R5 credit after", d, (m == 8 || m == 9 || m == 10 || m == 11 ||
                m == 12 || m == 13 || m == 14) ? (32'd1 << 8) : 32'd0);
        end

        // R9: hold while not ready
        wr(0, 2, 0);
        gnt_ready = 0;
        wr(0, 3, 32'd2 | (32'd1 << 3) | (32'd1 << 19));
        wr(1, 3, 32'd5 << 8);
        q_pend = 16'h0008;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 valid held", 32'(gnt_valid), 1);
            chk("R9 queue held", 32'(gnt_q), 3);
            chk("R9 channel held", 32'(gnt_ch), 2);
        end
        rd(1, 3, d); chk("R9 no credit while held", d, 32'd5 << 8);
        gnt_ready = 1;
        @(posedge clk);
        #1 q_pend = '0;
        @(negedge clk);
        chk("R9 released", 32'(gnt_valid), 0);
        rd(1, 3, d); chk("R5 single decrement", d, 32'd4 << 8);

        // R10: super-credit alone does not make a queue eligible
        wr(1, 3, 32'hFF00_0000);
        q_pend = 16'h0008;
        begin
            int ngr;
            ngr = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (gnt_valid) ngr++;
            end
            chk("R10 no grant on super-credit", 32'(ngr), 0);
        end
        q_pend = '0;
        rd(1, 3, d); chk("R10 context unchanged", d, 32'hFF00_0000);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule